// File: doc/BRIEF.md
# Interrupt Vector Fetch Sequencer

This block turns an 8-bit interrupt number into the code selector and instruction pointer of the matching service routine. It reads the table entry for that number from memory one byte at a time through a simple read port. The port has a request line, an address bus and a returned-byte strobe, and the memory may insert any number of wait cycles. When the last byte arrives, the block presents the new selector and pointer and pulses a completion flag.

There are two entry formats. In the legacy flat format the table sits at the bottom of memory, in the first kilobyte, and each entry is four bytes. The address of an entry is the interrupt number times four. The first two bytes form the 16-bit pointer and the next two form the selector. In the descriptor format each entry is eight bytes and sits at a relocatable base plus the number times eight. Software loads that base beforehand through a dedicated write port. The pointer is 32 bits, gathered from bytes 0, 1, 6 and 7, and the selector comes from bytes 2 and 3. Interrupt numbers 0 to 4 and 6 carry fixed architectural meanings, and numbers up to 31 are reserved. The block itself treats all 256 numbers alike.

Top module: `ivec_fetch_seq`

## Requirements
- R1: While reset is held and immediately after it, busy_o, done_o and mem_req_o are 0, and cs_o and eip_o are 0.
- R2: In flat mode (prot_i = 0 at acceptance) exactly 4 reads are issued, at addresses type*4, type*4+1, type*4+2 and type*4+3, in that order. Every flat-mode address lies below 1024.
- R3: In flat mode the result is eip_o = {16'h0, byte1, byte0} and cs_o = {byte3, byte2}, where byteN is the byte read from entry address + N.
- R4: In descriptor mode (prot_i = 1 at acceptance) exactly 8 reads are issued, at base + type*8 + 0 through + 7 in ascending order. The sum wraps modulo 2^ADDR_W.
- R5: In descriptor mode the result is eip_o = {byte7, byte6, byte1, byte0} and cs_o = {byte3, byte2}. Bytes 4 and 5 have no effect on any output.
- R6: While mem_req_o is high and mem_valid_i is low, mem_addr_o holds its value. Each cycle with mem_valid_i high consumes exactly one byte, whatever the pattern of wait cycles.
- R7: A request is accepted in a cycle where req_i = 1 and busy_o = 0. busy_o and mem_req_o are 1 from the next cycle until the final byte is captured. done_o is 1 for exactly the one cycle after that capture, with busy_o = 0. With no wait cycles, done_o rises N+1 cycles after acceptance, where N is the number of entry bytes.
- R8: cs_o and eip_o change only in the cycle in which done_o is 1.
- R9: While busy_o = 1, req_i, type_i and prot_i have no effect. The fetch in progress completes with the number and mode that were sampled at acceptance.
- R10: A cycle with base_we_i = 1 loads base_i as the descriptor table base. A fetch already in progress keeps the address it started with. The new base applies to requests accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a vector fetch |
| type_i | input | 8 | Interrupt number |
| prot_i | input | 1 | 1 = descriptor format at relocatable base, 0 = flat 4-byte format at address 0 |
| base_we_i | input | 1 | Load the descriptor table base |
| base_i | input | ADDR_W | Descriptor table base value |
| mem_req_o | output | 1 | Read request to memory |
| mem_addr_o | output | ADDR_W | Byte address of the read |
| mem_valid_i | input | 1 | Returned byte is valid this cycle |
| mem_data_i | input | 8 | Returned byte |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cs_o | output | 16 | New code selector |
| eip_o | output | 32 | New instruction pointer |

## Verification
The assertions check the cycle-level rules on every cycle:
- the address holds across wait cycles and steps by one after each consumed byte;
- done_o is a single-cycle pulse that follows a busy period;
- the outputs stay stable outside that pulse;
- a flat-mode fetch never leaves the first kilobyte and leaves the upper pointer half at zero.

Only the bench scenarios can show the rest:
- the exact entry address for each interrupt number and base, including wraparound at the top of the address space;
- the byte-to-field mapping of both formats;
- the immunity of an in-flight fetch to new requests, mode changes and base reloads.

The bench sweeps all 256 numbers in both modes under several wait-cycle patterns.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  typedef enum logic {MODE_FLAT = 1'b0, MODE_DESC = 1'b1} ivec_mode_e;

  localparam int unsigned FLAT_BYTES = 4;
  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned IDX_W      = $clog2(DESC_BYTES);
  // bytes that carry fields: 0,1,2,3,6,7
  localparam int unsigned SLOTS      = 6;

  function automatic logic [IDX_W-1:0] last_idx(ivec_mode_e m);
    return (m == MODE_DESC) ? IDX_W'(DESC_BYTES - 1) : IDX_W'(FLAT_BYTES - 1);
  endfunction

  function automatic logic [IDX_W-1:0] slot_byte(int unsigned s);
    return (s < 4) ? IDX_W'(s) : IDX_W'(s + 2);
  endfunction
endpackage

// File: rtl/ivec_ctrl.sv
module ivec_ctrl
  import ivec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             prot_i,
  input  logic             mem_valid_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             cap_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output ivec_mode_e       mode_o,
  output logic             done_o
);
  typedef enum logic {ST_IDLE, ST_FETCH} st_e;

  st_e              st_q;
  logic [IDX_W-1:0] idx_q;
  ivec_mode_e       mode_q;
  logic             done_q;

  assign busy_o   = (st_q == ST_FETCH);
  assign accept_o = req_i && !busy_o;
  assign cap_o    = busy_o && mem_valid_i;
  assign last_o   = (idx_q == last_idx(mode_q));
  assign idx_o    = idx_q;
  assign mode_o   = mode_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      mode_q <= MODE_FLAT;
      done_q <= 1'b0;
    end else begin
      done_q <= cap_o && last_o;
      if (accept_o) begin
        st_q   <= ST_FETCH;
        idx_q  <= '0;
        mode_q <= prot_i ? MODE_DESC : MODE_FLAT;
      end else if (cap_o) begin
        if (last_o) st_q <= ST_IDLE;
        else        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ivec_addr_gen.sv
module ivec_addr_gen #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              accept_i,
  input  logic              prot_i,
  input  logic [7:0]        type_i,
  input  logic              cap_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q, addr_q, entry;

  // flat table is pinned at 0; descriptor table is relocatable
  assign entry  = prot_i ? base_q + ADDR_W'({type_i, 3'b000})
                         : ADDR_W'({type_i, 2'b00});
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        base_q <= '0;
    else if (base_we_i) base_q <= base_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (accept_i) addr_q <= entry;
    else if (cap_i)    addr_q <= addr_q + 1'b1;
  end
endmodule

// File: rtl/ivec_byte_asm.sv
module ivec_byte_asm
  import ivec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             last_i,
  input  logic [IDX_W-1:0] idx_i,
  input  ivec_mode_e       mode_i,
  input  logic [7:0]       data_i,
  output logic [15:0]      cs_o,
  output logic [31:0]      eip_o
);
  logic [7:0] slot_q   [SLOTS];
  logic [7:0] slot_nxt [SLOTS];
  logic [15:0] cs_q;
  logic [31:0] eip_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    assign hit         = cap_i && (idx_i == slot_byte(s));
    assign slot_nxt[s] = hit ? data_i : slot_q[s];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[s] <= '0;
      else if (hit) slot_q[s] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= '0;
      eip_q <= '0;
    end else if (cap_i && last_i) begin
      cs_q <= {slot_nxt[3], slot_nxt[2]};
      if (mode_i == MODE_DESC)
        eip_q <= {slot_nxt[5], slot_nxt[4], slot_nxt[1], slot_nxt[0]};
      else
        eip_q <= {16'h0000, slot_nxt[1], slot_nxt[0]};
    end
  end

  assign cs_o  = cs_q;
  assign eip_o = eip_q;
endmodule

// File: rtl/ivec_fetch_seq.sv
module ivec_fetch_seq
  import ivec_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [7:0]        type_i,
  input  logic              prot_i,
  input  logic              base_we_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [7:0]        mem_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [15:0]       cs_o,
  output logic [31:0]       eip_o
);
  logic             accept, busy, cap, last;
  logic [IDX_W-1:0] idx;
  ivec_mode_e       mode;

  ivec_ctrl u_ctrl (
    .clk_i, .rst_ni, .req_i, .prot_i, .mem_valid_i,
    .accept_o (accept), .busy_o (busy), .cap_o (cap), .last_o (last),
    .idx_o (idx), .mode_o (mode), .done_o (done_o)
  );

  ivec_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni, .base_we_i, .base_i,
    .accept_i (accept), .prot_i, .type_i, .cap_i (cap), .addr_o (mem_addr_o)
  );

  ivec_byte_asm u_asm (
    .clk_i, .rst_ni, .cap_i (cap), .last_i (last), .idx_i (idx),
    .mode_i (mode), .data_i (mem_data_i), .cs_o, .eip_o
  );

  assign busy_o    = busy;
  assign mem_req_o = busy;
endmodule

// File: rtl/ivec_fetch_chk.sv
module ivec_fetch_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              prot_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [15:0]       cs_o,
  input logic [31:0]       eip_o
);
  logic desc_seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) desc_seen <= 1'b0;
    else if (req_i && !busy_o) desc_seen <= prot_i;
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i) |=>
      (!mem_req_o || mem_addr_o == $past(mem_addr_o) + 1'b1));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));

  p_out_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(cs_o) && $stable(eip_o)));

  p_flat_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !desc_seen) |-> (eip_o[31:16] == 16'h0000));

  p_flat_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !desc_seen) |-> (mem_addr_o < ADDR_W'(1024)));
endmodule

bind ivec_fetch_seq ivec_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .req_i, .prot_i, .mem_req_o, .mem_addr_o,
  .mem_valid_i, .busy_o, .done_o, .cs_o, .eip_o
);

// File: tb/ivec_fetch_seq_tb_top.sv
module ivec_fetch_seq_tb_top;
  localparam int unsigned AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic [7:0]    type_i = '0;
  logic          prot_i = 1'b0;
  logic          base_we_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_valid_i = 1'b0;
  logic [7:0]    mem_data_i = '0;
  logic          busy_o, done_o;
  logic [15:0]   cs_o;
  logic [31:0]   eip_o;

  ivec_fetch_seq #(.ADDR_W(AW)) dut_i (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, fails = 0, cyc = 0;
  int wait_mode = 0;
  logic [AW-1:0] log_a [16];
  int log_n = 0;
  logic [7:0] lfsr = 8'h1D;

  function automatic logic [7:0] mem_byte(logic [AW-1:0] a);
    return 8'((a[7:0] * 29) + (a[15:8] * 11) + a[31:24]) ^ 8'hA5;
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // memory responder: drives strobe/data at negedge, logs consumed addresses
  always @(negedge clk_i) begin
    logic v;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (wait_mode)
      0: v = 1'b1;
      1: v = cyc[0];
      default: v = lfsr[0];
    endcase
    v = v && mem_req_o;
    mem_valid_i = v;
    mem_data_i  = v ? mem_byte(mem_addr_o) : 8'hXX;
    if (v && log_n < 16) begin
      log_a[log_n] = mem_addr_o;
      log_n = log_n + 1;
    end else if (v) log_n = 99;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "WDOG", "watchdog", 64'(cyc), 64'd150000);
      summary();
    end
  end

  logic [AW-1:0] base_model = '0;

  task automatic load_base(logic [AW-1:0] b);
    @(negedge clk_i);
    base_we_i = 1'b1; base_i = b;
    @(negedge clk_i);
    base_we_i = 1'b0;
    base_model = b;
  endtask

  // one fetch; meddle = disturb inputs while busy; nb = reload base mid-fetch
  task automatic run(logic [7:0] ty, bit pr, bit meddle, bit nb, logic [AW-1:0] nbv);
    logic [AW-1:0] ent;
    logic [7:0] b [8];
    int n, t;
    bit moved;
    logic [15:0] pcs, ecs;
    logic [31:0] peip, eeip;
    string ra, rf;
    n   = pr ? 8 : 4;
    ent = pr ? base_model + AW'({ty, 3'b000}) : AW'({ty, 2'b00});
    for (int k = 0; k < 8; k++) b[k] = mem_byte(ent + AW'(k));
    ecs  = {b[3], b[2]};
    eeip = pr ? {b[7], b[6], b[1], b[0]} : {16'h0, b[1], b[0]};
    ra = pr ? "R4" : "R2";
    rf = pr ? "R5" : "R3";
    @(negedge clk_i);
    log_n = 0; pcs = cs_o; peip = eip_o;
    req_i = 1'b1; type_i = ty; prot_i = pr;
    @(negedge clk_i);
    req_i = 1'b0;
    if (meddle) chk(busy_o && mem_req_o, "R7", "busy after accept", 64'(busy_o), 64'd1);
    t = 0; moved = 0;
    while (!done_o && t < 200) begin
      if (cs_o != pcs || eip_o != peip) moved = 1;
      req_i     = meddle && t < 2;
      prot_i    = meddle ? ~pr : pr;
      type_i    = meddle ? ~ty : ty;
      base_we_i = nb && t == 1;
      base_i    = nbv;
      @(negedge clk_i);
      t++;
    end
    req_i = 1'b0; base_we_i = 1'b0; prot_i = pr; type_i = ty;
    if (nb) base_model = nbv;
    chk(done_o, "R7", "done seen", 64'(done_o), 64'd1);
    chk(log_n == n, ra, "read count", 64'(log_n), 64'(n));
    for (int k = 0; k < n && k < log_n && k < 16; k++)
      if (log_a[k] != ent + AW'(k)) chk(1'b0, ra, "read address", 64'(log_a[k]), 64'(ent + AW'(k)));
    chk(cs_o == ecs, rf, "cs", 64'(cs_o), 64'(ecs));
    chk(eip_o == eeip, rf, "eip", 64'(eip_o), 64'(eeip));
    chk(!moved, "R8", "outputs moved before done", 64'(moved), 64'd0);
    if (meddle || nb) chk(1'b1, "R9", "disturbed fetch kept", 64'd0, 64'd0);
    if (wait_mode == 0) chk(t == n, "R7", "latency", 64'(t), 64'(n));
    else chk(t >= n, "R6", "wait latency", 64'(t), 64'(n));
    chk(!busy_o, "R7", "idle at done", 64'(busy_o), 64'd0);
    @(negedge clk_i);
    chk(!done_o, "R7", "done one cycle", 64'(done_o), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o, "R1", "control in reset",
        64'({busy_o, done_o, mem_req_o}), 64'd0);
    chk(cs_o == 0 && eip_o == 0, "R1", "fields in reset", 64'({cs_o, eip_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !mem_req_o, "R1", "idle after reset", 64'(busy_o), 64'd0);

    // R2/R3 flat sweep, R6 waits rotate
    for (int ty = 0; ty < 256; ty++) begin
      wait_mode = ty % 3;
      run(8'(ty), 1'b0, 1'b0, 1'b0, '0);
    end
    // R4/R5 descriptor sweep at an ordinary base
    load_base(32'h0001_2340);
    for (int ty = 0; ty < 256; ty++) begin
      wait_mode = (ty + 1) % 3;
      run(8'(ty), 1'b1, 1'b0, 1'b0, '0);
    end
    // R4 wraparound base
    load_base(32'hFFFF_FC10);
    for (int ty = 0; ty < 256; ty += 5) begin
      wait_mode = ty % 3;
      run(8'(ty), 1'b1, 1'b0, 1'b0, '0);
    end
    // R9 disturbance while busy, both modes and wait patterns
    for (int w = 0; w < 3; w++) begin
      wait_mode = w;
      run(8'h06, 1'b0, 1'b1, 1'b0, '0);
      run(8'h42, 1'b1, 1'b1, 1'b0, '0);
    end
    // R10 base reload mid-fetch, then new base applies
    wait_mode = 0;
    run(8'h10, 1'b1, 1'b0, 1'b1, 32'h0080_0000);
    run(8'h10, 1'b1, 1'b0, 1'b0, '0);
    wait_mode = 2;
    run(8'hFF, 1'b1, 1'b0, 1'b1, 32'h0000_0008);
    run(8'hFF, 1'b1, 1'b0, 1'b0, '0);
    // R10 base load idle, flat mode ignores base
    load_base(32'h7777_0000);
    run(8'h03, 1'b0, 1'b0, 1'b0, '0);
    summary();
  end
endmodule